// File: doc/BRIEF.md
# IDE PIO Command Timing Generator

This block runs a single programmed-I/O register access, read or write, to one of the two drives on an IDE channel. An accepted request is turned into a three-phase bus cycle. The first phase holds the address and chip select with both strobes high. The second phase drives the read or write strobe low. The third phase returns the strobe high for recovery while the address is still held. Every phase length is counted in clock cycles from fields of a 32-bit timing word. Each drive has its own timing word, and the drive named in the request picks which word is used.

The device can stretch the strobe-low phase by holding its ready line negated. That line passes through a two-flop synchronizer. It is sampled at the end of the programmed low time, and the block keeps the strobe low until the synchronized line goes high. A timeout bounds the wait. When the timeout expires, the cycle still completes and an error flag is raised beside the done pulse. Read data is captured from the bus on the clock edge that ends the strobe.

The request side uses valid/ready. `req_ready` is high only while no cycle is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its fields and the selected timing word are latched at that edge. `req_valid` may stay high while the block is busy and is ignored until `req_ready` returns. The completion side has no back-pressure: `done` is a one-cycle pulse, `tmo_err` is valid only with it, and `rd_data` holds its value until the next read.

Top module: `ide_pio_timing`

## Requirements
- R1: While reset is asserted and right after it is released, both strobes and both chip selects are high, `dd_oe` and `done` are low, and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the first idle cycle after recovery, and a `req_valid` seen in that interval has no effect.
- R3: `req_drive` = 0 uses `tim_drv0`, and `req_drive` = 1 uses `tim_drv1`. The word is sampled when the request is accepted.
- R4: The setup phase lasts P+1 cycles, where P is the timing word's bits 21:19. During setup the address and chip select are driven and both strobes are high.
- R5: The strobe is low for L+1 cycles when the device is ready, where L is bits 15:12. `dior_n` is the strobe for a read (`req_rd` = 1) and `diow_n` is the strobe for a write. The two are never low together.
- R6: Recovery lasts H+1 cycles, where H is bits 11:8, with both strobes high and the address held. `done` is high for exactly the first cycle after recovery.
- R7: `iordy` is passed through two flops. If the synchronized value is low in the last programmed low cycle, the strobe stays low until a cycle in which it is high. Recovery follows that cycle.
- R8: If the synchronized `iordy` stays low for TMO_CYCLES wait cycles (default 64), the strobe ends and recovery runs. `tmo_err` is then high together with `done`, and it is low with `done` on every other completion.
- R9: On a read, `dd_in` is captured into `rd_data` on the edge that ends the strobe-low phase. `rd_data` keeps its value through writes and idle time.
- R10: On a write, `dd_oe` is high and `dd_out` equals the accepted write data from the first setup cycle to the last recovery cycle. `dd_oe` is low at all other times and for reads.
- R11: `da` equals request address bits 2:0. Address bit 3 set asserts `cs1_n` and clear asserts `cs0_n`, in every cycle from setup through recovery. Timing-word bits other than the three fields (including 18:16) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rd | input | 1 | 1 = register read, 0 = write |
| req_addr | input | 4 | Bit 3 chip-select choice, bits 2:0 register address |
| req_drive | input | 1 | Drive select, picks the timing word |
| req_wdata | input | 16 | Write data |
| tim_drv0 | input | 32 | Timing word for drive 0 |
| tim_drv1 | input | 32 | Timing word for drive 1 |
| iordy | input | 1 | Device ready, asynchronous |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| da | output | 3 | Device register address |
| cs0_n | output | 1 | Command-block chip select, active low |
| cs1_n | output | 1 | Control-block chip select, active low |
| dd_out | output | 16 | Data driven to the bus |
| dd_oe | output | 1 | Data output enable |
| dd_in | input | 16 | Data from the bus |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Wait ended by timeout, valid with done |

## Verification
The assertions assume that `req_valid` and the request fields are stable around the clock edge where they are sampled. They also assume that `iordy` reaches the design only through the synchronizer, so the wait logic sees a clean level. The bench meets both assumptions by changing every input on the falling clock edge. It holds `dd_in` constant for the whole transaction, so the value captured at the strobe-ending edge is known in advance. Its `iordy` patterns cover three cases: always ready, released a fixed number of cycles after the request, and held low past the timeout.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int PRE_W   = 3;
  localparam int CNT_W   = 4;
  localparam int PRE_LSB = 19;
  localparam int LOW_LSB = 12;
  localparam int HI_LSB  = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_WAIT, PH_RECOV
  } pio_phase_t;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] low;
    logic [CNT_W-1:0] high;
  } pio_tim_t;
endpackage

// File: rtl/ide_iordy_sync.sv
module ide_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '1;
        else        sh <= async_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], async_in};
    end
  endgenerate

  assign sync_out = sh[STAGES-1];
endmodule

// File: rtl/ide_tim_select.sv
module ide_tim_select
  import ide_pio_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic              sel,
  output pio_tim_t          tim
);
  logic [WORD_W-1:0] w;
  logic              unused_bits;

  assign w = sel ? word1 : word0;
  assign tim.pre  = w[PRE_LSB +: PRE_W];
  assign tim.low  = w[LOW_LSB +: CNT_W];
  assign tim.high = w[HI_LSB  +: CNT_W];
  assign unused_bits = ^{w[WORD_W-1:PRE_LSB+PRE_W], w[PRE_LSB-1:LOW_LSB+CNT_W],
                         w[HI_LSB-1:0]};
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int DW         = 16,
  parameter int TMO_CYCLES = 64,
  localparam int WCW       = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pio_tim_t      tim,
  input  logic          is_rd,
  input  logic          iordy_s,
  input  logic [DW-1:0] dd_in,
  output pio_phase_t    phase,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata
);
  pio_tim_t        tim_q;
  logic [CNT_W-1:0] cnt;
  logic [WCW-1:0]   wcnt;
  logic             err_l;
  logic             wait_over;

  assign wait_over = iordy_s || (wcnt == WCW'(TMO_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tim_q <= '0;
      cnt   <= '0;
      wcnt  <= '0;
      err_l <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          tim_q <= tim;
          cnt   <= CNT_W'(tim.pre);
          err_l <= 1'b0;
          phase <= PH_SETUP;
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= tim_q.low;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          if (iordy_s) begin
            phase <= PH_RECOV;
            cnt   <= tim_q.high;
            if (is_rd) rdata <= dd_in;
          end else begin
            phase <= PH_WAIT;
            wcnt  <= '0;
          end
        end else cnt <= cnt - 1'b1;
        PH_WAIT: if (wait_over) begin
          phase <= PH_RECOV;
          cnt   <= tim_q.high;
          err_l <= !iordy_s;
          if (is_rd) rdata <= dd_in;
        end else wcnt <= wcnt + 1'b1;
        PH_RECOV: if (cnt == '0) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
          err   <= err_l;
        end else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8: timeout flag only appears with completion
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a ready device ends the wait on the next edge
  a_r7_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && iordy_s) |=> (phase == PH_RECOV));
endmodule

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
  import ide_pio_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int WORD_W      = 32,
  parameter int TMO_CYCLES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rd,
  input  logic [AW:0]       req_addr,
  input  logic              req_drive,
  input  logic [DW-1:0]     req_wdata,
  input  logic [WORD_W-1:0] tim_drv0,
  input  logic [WORD_W-1:0] tim_drv1,
  input  logic              iordy,
  output logic              dior_n,
  output logic              diow_n,
  output logic [AW-1:0]     da,
  output logic              cs0_n,
  output logic              cs1_n,
  output logic [DW-1:0]     dd_out,
  output logic              dd_oe,
  input  logic [DW-1:0]     dd_in,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic              tmo_err
);
  pio_tim_t   tim_sel;
  pio_phase_t phase;
  logic       iordy_s;
  logic       accept;
  logic       busy;
  logic       strobe;
  logic       rd_q;
  logic [AW:0]   addr_q;
  logic [DW-1:0] wd_q;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = !req_ready;
  assign strobe    = (phase == PH_STROBE) || (phase == PH_WAIT);

  ide_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(iordy), .sync_out(iordy_s));

  ide_tim_select #(.WORD_W(WORD_W)) u_tsel (
    .word0(tim_drv0), .word1(tim_drv1), .sel(req_drive), .tim(tim_sel));

  ide_pio_seq #(.DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .tim(tim_sel), .is_rd(rd_q),
    .iordy_s(iordy_s), .dd_in(dd_in), .phase(phase), .done(done),
    .err(tmo_err), .rdata(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      rd_q   <= req_rd;
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  assign dior_n = !(strobe && rd_q);
  assign diow_n = !(strobe && !rd_q);
  assign da     = addr_q[AW-1:0];
  assign cs0_n  = !(busy && !addr_q[AW]);
  assign cs1_n  = !(busy && addr_q[AW]);
  assign dd_oe  = busy && !rd_q;
  assign dd_out = wd_q;

  // R5: never both strobes at once
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dior_n || diow_n);
  // R2: no strobe while the request side reports idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dior_n && diow_n && cs0_n && cs1_n));
  // R11: address and selects steady for the whole cycle
  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(da) && $stable(cs0_n) && $stable(cs1_n)));
endmodule

// File: tb/ide_pio_timing_tb.sv
module ide_pio_timing_tb;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0, req_drive = 1'b0, iordy = 1'b1;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, dd_in = '0;
  logic [31:0] tim0 = '0, tim1 = '0;
  logic req_ready, dior_n, diow_n, cs0_n, cs1_n, dd_oe, done, tmo_err;
  logic [2:0]  da;
  logic [15:0] dd_out, rd_data;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  ide_pio_timing u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_addr(req_addr), .req_drive(req_drive),
    .req_wdata(req_wdata), .tim_drv0(tim0), .tim_drv1(tim1), .iordy(iordy),
    .dior_n(dior_n), .diow_n(diow_n), .da(da), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in), .rd_data(rd_data),
    .done(done), .tmo_err(tmo_err));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 setup,2 low,3 wait,4 recovery
  int m_ph = 0, m_left = 0, m_wn = 0, m_pre = 0, m_low = 0, m_high = 0;
  bit m_rd = 0, m_done = 0, m_err = 0, m_errl = 0, s1 = 1, s2 = 1;
  logic [3:0]  m_addr = '0;
  logic [15:0] m_wd = '0, m_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_done <= 0; m_err <= 0; s1 <= 1; s2 <= 1;
      m_rdata <= '0; m_addr <= '0; m_rd <= 0; m_wd <= '0;
    end else begin
      logic [31:0] w;
      w = req_drive ? tim1 : tim0;
      s1 <= iordy; s2 <= s1;
      m_done <= 0; m_err <= 0;
      case (m_ph)
        0: if (req_valid) begin
          m_rd <= req_rd; m_addr <= req_addr; m_wd <= req_wdata;
          m_pre <= int'(w[21:19]); m_low <= int'(w[15:12]); m_high <= int'(w[11:8]);
          m_left <= int'(w[21:19]); m_errl <= 0; m_ph <= 1;
        end
        1: if (m_left == 0) begin m_ph <= 2; m_left <= m_low; end else m_left <= m_left - 1;
        2: if (m_left == 0) begin
          if (s2) begin m_ph <= 4; m_left <= m_high; if (m_rd) m_rdata <= dd_in; end
          else begin m_ph <= 3; m_wn <= 0; end
        end else m_left <= m_left - 1;
        3: if (s2 || m_wn == TMO - 1) begin
          m_ph <= 4; m_left <= m_high; m_errl <= !s2; if (m_rd) m_rdata <= dd_in;
        end else m_wn <= m_wn + 1;
        4: if (m_left == 0) begin m_ph <= 0; m_done <= 1; m_err <= m_errl; end
           else m_left <= m_left - 1;
        default: m_ph <= 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit act;
    act = (m_ph != 0);
    chk(req_ready == !act, "R2 req_ready", req_ready, !act);
    chk(dior_n == !(m_rd && (m_ph == 2 || m_ph == 3)), "R5 dior_n", dior_n, !(m_rd && (m_ph == 2 || m_ph == 3)));
    chk(diow_n == !(!m_rd && (m_ph == 2 || m_ph == 3)), "R5 diow_n", diow_n, !(!m_rd && (m_ph == 2 || m_ph == 3)));
    chk(cs0_n == !(act && !m_addr[3]), "R11 cs0_n", cs0_n, !(act && !m_addr[3]));
    chk(cs1_n == !(act && m_addr[3]), "R11 cs1_n", cs1_n, !(act && m_addr[3]));
    if (act) chk(da == m_addr[2:0], "R11 da", da, m_addr[2:0]);
    chk(dd_oe == (act && !m_rd), "R10 dd_oe", dd_oe, act && !m_rd);
    if (dd_oe) chk(dd_out == m_wd, "R10 dd_out", dd_out, m_wd);
    chk(rd_data == m_rdata, "R9 rd_data", rd_data, m_rdata);
    chk(done == m_done, "R6 done", done, m_done);
    chk(tmo_err == m_err, "R8 tmo_err", tmo_err, m_err);
  end

  function automatic logic [31:0] mkword(input int pre, input int low, input int high, input logic [31:0] junk);
    logic [31:0] w;
    w = junk;
    w[21:19] = pre[2:0]; w[15:12] = low[3:0]; w[11:8] = high[3:0];
    return w;
  endfunction

  int n_setup, n_low, n_rec;
  bit last_err;

  // rel: cycle index after acceptance at which iordy is raised (-1 = never)
  task automatic run(input bit rd, input logic [3:0] addr, input bit drv,
                     input logic [15:0] wd, input int pre, input int low,
                     input int high, input int rel, input bit spam);
    bit seen;
    int k;
    if (drv) begin tim1 = mkword(pre, low, high, 32'h5A5F_00C3); tim0 = mkword(7, 15, 15, '1); end
    else     begin tim0 = mkword(pre, low, high, 32'hFFC7_00FF); tim1 = mkword(7, 15, 15, '1); end
    req_rd = rd; req_addr = addr; req_drive = drv; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    if (spam) begin req_addr = ~addr; req_wdata = ~wd; req_rd = !rd; req_drive = !drv; end
    else req_valid = 1'b0;
    n_setup = 0; n_low = 0; n_rec = 0; seen = 0; k = 0;
    while (!done && k < 2000) begin
      if (!dior_n || !diow_n) begin n_low++; seen = 1; end
      else if (!seen) n_setup++;
      else n_rec++;
      if (k == 1) req_valid = 1'b0;
      k++;
      if (k == rel) iordy = 1'b1;
      @(negedge clk);
    end
    last_err = tmo_err;
    chk(done == 1'b1, "R6 completion seen", done, 1);
    chk(n_setup == pre + 1, "R4 setup length", n_setup, pre + 1);
    chk(n_rec == high + 1, "R6 recovery length", n_rec, high + 1);
    iordy = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dior_n && diow_n && cs0_n && cs1_n, "R1 strobes/selects in reset", {dior_n, diow_n, cs0_n, cs1_n}, 4'hF);
    chk(!dd_oe && !done && req_ready, "R1 oe/done/ready in reset", {dd_oe, done, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && dior_n && diow_n, "R1 idle after reset", {req_ready, dior_n, diow_n}, 3'b111);

    dd_in = 16'hBEEF;
    run(1, 4'h7, 0, 16'h0, 1, 3, 2, -1, 0);
    chk(n_low == 4, "R5 read strobe length drive0", n_low, 4);
    chk(rd_data == 16'hBEEF, "R9 read capture", rd_data, 16'hBEEF);
    chk(!last_err, "R8 no error when ready", last_err, 0);

    run(0, 4'hE, 1, 16'h1234, 0, 0, 0, -1, 0);
    chk(n_low == 1, "R3 drive1 word minimal strobe", n_low, 1);
    chk(rd_data == 16'hBEEF, "R9 rd_data kept over write", rd_data, 16'hBEEF);

    run(0, 4'h2, 1, 16'hA5C3, 5, 6, 4, -1, 1);
    chk(n_low == 7, "R2 busy request ignored, R5 length", n_low, 7);
    @(negedge clk);
    chk(req_ready && dd_oe == 0, "R2 no extra cycle from held valid", {req_ready, dd_oe}, 2'b10);

    dd_in = 16'h0F0F; iordy = 1'b0;
    run(1, 4'h8, 0, 16'h0, 2, 1, 3, 9, 0);
    chk(n_low > 2, "R7 strobe stretched", n_low, 3);
    chk(!last_err, "R7 no error on release", last_err, 0);

    dd_in = 16'h7E57; iordy = 1'b0;
    run(1, 4'h1, 1, 16'h0, 0, 2, 1, -1, 0);
    chk(n_low == 3 + TMO, "R8 timeout length", n_low, 3 + TMO);
    chk(last_err, "R8 error flag", last_err, 1);
    chk(rd_data == 16'h7E57, "R9 capture on timeout", rd_data, 16'h7E57);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule